// File: doc/BRIEF.md
# SPI byte FIFO status and interrupt unit

This unit sits between an SPI shift engine and the CPU bus. It buffers received bytes and bytes waiting to be sent, each in a small first-in first-out queue of four entries. It also keeps a 16-bit read-only status word. That word holds both fill levels, a live flag that is high while the receive side has passed a programmed threshold, and five sticky event flags. The sticky flags clear when software reads the word. The unit drives one interrupt line, built from the sticky flags and two error masks.

The shift engine delivers each received byte as a one-cycle push and takes transmit bytes with a one-cycle start strobe. Neither of these paths can be stalled. A received byte that finds the queue full is dropped and recorded as an overflow. A start that finds no data sends 0x00 and is recorded as an underflow.

The CPU side uses valid/ready handshakes:
- Receive pop: a byte moves out on a cycle where `rx_pop_valid` and `rx_pop_ready` are both high. `rx_pop_valid` is high whenever the receive queue holds data.
- Transmit push: a byte moves in on a cycle where `tx_push_valid` and `tx_push_ready` are both high. `tx_push_ready` drops while the transmit queue is full, and this is the only back-pressure in the block.

A single mode bit selects whether the data interrupt follows the receive side or the transmit side.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset the status word is 0x0000, `irq` is 0, `rx_pop_valid` is 0 and `tx_push_ready` is 1.
- R2: Status bits 3:1 carry the transmit fill count and bits 10:8 the receive fill count, each from 0 to 4. Bits 15:12 always read 0. Counts change in the cycle after the push or pop.
- R3: A receive push is accepted when the receive queue is not full or a pop happens in the same cycle. Otherwise the byte is discarded, the contents are unchanged, and bit 7 (receive overflow) is set.
- R4: `tx_shift_data` shows the oldest transmit byte, or 0x00 when the queue is empty. A `tx_start` with an empty queue sets bit 4 (transmit underflow) and leaves the count at 0. Otherwise `tx_start` removes the oldest byte.
- R5: Bit 11 is live. It is 1 exactly while the receive count is greater than `rx_threshold`.
- R6: With `irq_dir_tx`=0, an accepted receive byte that leaves the receive count greater than `rx_threshold` sets bit 6 (receive data event).
- R7: With `irq_dir_tx`=1, a `tx_start` that removes the last byte sets bit 5 (transmit data event). Removing the last byte means the count goes from 1 to 0 with no push in the same cycle.
- R8: Bit 0 is set by any enabled event. The enabled events are a receive overflow with `mask_rx_ovf`=0, an underflow with `mask_tx_udf`=0, a receive data event, or a transmit data event.
- R9: A `status_rd` cycle shows the current word. In the next cycle bits 7, 6, 5, 4 and 0 are 0, except that a flag whose event happens in the read cycle stays set.
- R10: `irq` is high while any of the following holds: bit 6, bit 5, bit 7 with `mask_rx_ovf`=0, or bit 4 with `mask_tx_udf`=0.
- R11: Both queues keep byte order. A push and a pop on one queue in the same cycle leave its count unchanged.
- R12: `tx_push_ready` is low exactly while the transmit queue holds 4 bytes. `rx_pop_valid` is high exactly while the receive queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push_valid | input | 1 | Shift engine delivers a received byte (no back-pressure) |
| rx_push_data | input | 8 | Received byte |
| rx_pop_valid | output | 1 | Receive queue holds a byte |
| rx_pop_ready | input | 1 | CPU takes the oldest received byte |
| rx_pop_data | output | 8 | Oldest received byte |
| tx_push_valid | input | 1 | CPU offers a byte to send |
| tx_push_ready | output | 1 | Transmit queue has room |
| tx_push_data | input | 8 | Byte to send |
| tx_start | input | 1 | Shift engine starts sending a byte |
| tx_shift_data | output | 8 | Byte that a start sends (0x00 when empty) |
| rx_threshold | input | 3 | Received-byte threshold |
| irq_dir_tx | input | 1 | 0: data interrupt from receive, 1: from transmit |
| mask_rx_ovf | input | 1 | Masks the overflow interrupt |
| mask_tx_udf | input | 1 | Masks the underflow interrupt |
| status_rd | input | 1 | Status word is read this cycle |
| status | output | 16 | Status word |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a status read in the same cycle as a new event. A typical example is a read that lands exactly on an overflow, while the receive queue is full and a pop is also pending. The bench covers it in two ways. It first fills the receive queue, then issues a push, a read and, in a separate case, a push with a pop, all aligned on one cycle. It then runs a long random phase in which reads, pushes, pops and starts are each frequent. A behavioural queue model checks every status field, `irq` and both data outputs on every clock.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int BYTE_W     = 8;
  localparam int FIFO_DEPTH = 4;
  localparam int STAT_W     = 16;
  localparam int FIELD_W    = 3;

  typedef struct packed {
    logic rx_ovf;
    logic rx_data;
    logic tx_data;
    logic tx_udf;
  } evt_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_hold_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t ev,
  input  logic status_rd,
  input  logic mask_rx_ovf,
  input  logic mask_tx_udf,
  output evt_t flags,
  output logic summary,
  output logic irq
);
  logic sum_ev;

  assign sum_ev = (ev.rx_ovf & ~mask_rx_ovf) | (ev.tx_udf & ~mask_tx_udf)
                | ev.rx_data | ev.tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      summary <= 1'b0;
    end else if (status_rd) begin
      flags   <= ev;
      summary <= sum_ev;
    end else begin
      flags   <= evt_t'(flags | ev);
      summary <= summary | sum_ev;
    end
  end

  assign irq = flags.rx_data | flags.tx_data
             | (flags.rx_ovf & ~mask_rx_ovf)
             | (flags.tx_udf & ~mask_tx_udf);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && ev == '0) |=> (flags == '0 && !summary));
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && ev.rx_ovf) |=> flags.rx_ovf);
  p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rx_data || ev.tx_data) |=> summary);
  p_irq_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.rx_data || flags.tx_data) |-> irq);
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_pkg::*;
#(
  parameter int W     = BYTE_W,
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_push_valid,
  input  logic [W-1:0] rx_push_data,
  output logic         rx_pop_valid,
  input  logic         rx_pop_ready,
  output logic [W-1:0] rx_pop_data,
  input  logic         tx_push_valid,
  output logic         tx_push_ready,
  input  logic [W-1:0] tx_push_data,
  input  logic         tx_start,
  output logic [W-1:0] tx_shift_data,
  input  logic [2:0]   rx_threshold,
  input  logic         irq_dir_tx,
  input  logic         mask_rx_ovf,
  input  logic         mask_tx_udf,
  input  logic         status_rd,
  output logic [STAT_W-1:0] status,
  output logic         irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic [W-1:0] rx_head, tx_head;
  logic rx_pop, rx_acc, tx_pop, tx_acc;
  logic [CNT_W:0] rx_next;
  evt_t ev, flags;
  logic summary;
  logic excess;

  assign rx_pop = rx_pop_ready & ~rx_empty;
  assign rx_acc = rx_push_valid & (~rx_full | rx_pop);
  assign tx_acc = tx_push_valid & ~tx_full;
  assign tx_pop = tx_start & ~tx_empty;

  spi_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_rx (
    .clk, .rst_n, .push(rx_acc), .push_data(rx_push_data), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_tx (
    .clk, .rst_n, .push(tx_acc), .push_data(tx_push_data), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  assign rx_next = {1'b0, rx_cnt} + (CNT_W+1)'(rx_acc) - (CNT_W+1)'(rx_pop);

  always_comb begin
    ev         = '0;
    ev.rx_ovf  = rx_push_valid & ~rx_acc;
    ev.tx_udf  = tx_start & tx_empty;
    ev.rx_data = ~irq_dir_tx & rx_acc & (rx_next > (CNT_W+1)'(rx_threshold));
    ev.tx_data = irq_dir_tx & tx_pop & ~tx_acc & (tx_cnt == CNT_W'(1));
  end

  spi_status_flags u_flags (
    .clk, .rst_n, .ev, .status_rd, .mask_rx_ovf, .mask_tx_udf,
    .flags, .summary, .irq);

  assign excess = ({1'b0, rx_cnt} > (CNT_W+1)'(rx_threshold));

  assign status = {4'b0000, excess, FIELD_W'(rx_cnt), flags.rx_ovf,
                   flags.rx_data, flags.tx_data, flags.tx_udf,
                   FIELD_W'(tx_cnt), summary};

  assign rx_pop_valid  = ~rx_empty;
  assign rx_pop_data   = rx_head;
  assign tx_push_ready = ~tx_full;
  assign tx_shift_data = tx_empty ? '0 : tx_head;

  p_ovf_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_valid && rx_full && !rx_pop_ready) |=> (rx_cnt == CNT_W'(DEPTH)));
  p_udf_stays_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_empty && !tx_push_valid) |=> (tx_cnt == '0));
  p_txirq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev.tx_data |=> tx_empty);
endmodule

// File: tb/spi_fifo_status_tb.sv
module spi_fifo_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_push_valid = 0, rx_pop_ready = 0, tx_push_valid = 0, tx_start = 0;
  logic [7:0] rx_push_data = 0, tx_push_data = 0;
  logic [2:0] rx_threshold = 3'd2;
  logic irq_dir_tx = 0, mask_rx_ovf = 0, mask_tx_udf = 0, status_rd = 0;
  logic rx_pop_valid, tx_push_ready, irq;
  logic [7:0] rx_pop_data, tx_shift_data;
  logic [15:0] status;

  int total = 0, bad = 0, cycles = 0;

  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit f_ovf, f_rxd, f_txd, f_udf, f_sum;

  always #4 clk = ~clk;

  spi_fifo_status u_dut (
    .clk, .rst_n, .rx_push_valid, .rx_push_data, .rx_pop_valid, .rx_pop_ready,
    .rx_pop_data, .tx_push_valid, .tx_push_ready, .tx_push_data, .tx_start,
    .tx_shift_data, .rx_threshold, .irq_dir_tx, .mask_rx_ovf, .mask_tx_udf,
    .status_rd, .status, .irq);

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      {f_ovf, f_rxd, f_txd, f_udf, f_sum} = '0;
    end else begin
      bit rpop, racc, eovf, tpop, eudf, tpush, erxd, etxd, esum;
      int rnew;
      rpop  = rx_pop_ready && rxq.size() > 0;
      racc  = rx_push_valid && (rxq.size() < 4 || rpop);
      eovf  = rx_push_valid && !racc;
      tpop  = tx_start && txq.size() > 0;
      eudf  = tx_start && txq.size() == 0;
      tpush = tx_push_valid && txq.size() < 4;
      rnew  = rxq.size() + (racc ? 1 : 0) - (rpop ? 1 : 0);
      erxd  = !irq_dir_tx && racc && rnew > int'(rx_threshold);
      etxd  = irq_dir_tx && tpop && txq.size() == 1 && !tpush;
      esum  = (eovf && !mask_rx_ovf) || (eudf && !mask_tx_udf) || erxd || etxd;
      if (rpop) void'(rxq.pop_front());
      if (racc) rxq.push_back(rx_push_data);
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(tx_push_data);
      if (status_rd) {f_ovf, f_rxd, f_txd, f_udf, f_sum} = '0;
      f_ovf |= eovf; f_rxd |= erxd; f_txd |= etxd; f_udf |= eudf; f_sum |= esum;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    int ex_irq;
    chk("R2 reserved", int'(status[15:12]), 0);
    chk("R2 rx count", int'(status[10:8]), rxq.size());
    chk("R2 tx count", int'(status[3:1]), txq.size());
    chk("R5 excess", int'(status[11]), int'(rxq.size() > int'(rx_threshold)));
    chk("R3 R9 overflow flag", int'(status[7]), int'(f_ovf));
    chk("R6 R9 rx data flag", int'(status[6]), int'(f_rxd));
    chk("R7 R9 tx data flag", int'(status[5]), int'(f_txd));
    chk("R4 R9 underflow flag", int'(status[4]), int'(f_udf));
    chk("R8 summary", int'(status[0]), int'(f_sum));
    ex_irq = int'(f_rxd || f_txd || (f_ovf && !mask_rx_ovf) || (f_udf && !mask_tx_udf));
    chk("R10 irq", int'(irq), ex_irq);
    chk("R12 rx valid", int'(rx_pop_valid), int'(rxq.size() > 0));
    chk("R12 tx ready", int'(tx_push_ready), int'(txq.size() < 4));
    if (rxq.size() > 0) chk("R11 rx order", int'(rx_pop_data), int'(rxq[0]));
    chk("R4 R11 tx data", int'(tx_shift_data), txq.size() > 0 ? int'(txq[0]) : 0);
  endtask

  // Drive the current inputs for one edge, then check and release strobes
  task automatic step();
    @(posedge clk);
    #2;
    cycles++;
    compare_all();
    rx_push_valid = 0; rx_pop_ready = 0; tx_push_valid = 0;
    tx_start = 0; status_rd = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000000;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rx valid", int'(rx_pop_valid), 0);
    chk("R1 tx ready", int'(tx_push_ready), 1);
    rst_n = 1;
    step();

    // R3 R6: five receive bytes with threshold 2, the fifth overflows
    for (int i = 0; i < 5; i++) begin
      rx_push_valid = 1; rx_push_data = 8'h10 + 8'(i); step();
    end
    // R9: read together with another overflow, event wins
    rx_push_valid = 1; rx_push_data = 8'hEE; status_rd = 1; step();
    status_rd = 1; step();
    // R11 R3: push while full with a pop in the same cycle
    rx_push_valid = 1; rx_push_data = 8'h55; rx_pop_ready = 1; step();
    rx_pop_ready = 1; status_rd = 1; step();
    repeat (4) begin rx_pop_ready = 1; step(); end

    // R4: underflow unmasked, then masked
    tx_start = 1; step();
    status_rd = 1; step();
    mask_tx_udf = 1; tx_start = 1; step();
    step();
    status_rd = 1; step();
    mask_tx_udf = 0;

    // R7 R12: fill transmit queue, try a fifth, drain in transmit mode
    irq_dir_tx = 1;
    for (int i = 0; i < 5; i++) begin
      tx_push_valid = 1; tx_push_data = 8'hA0 + 8'(i); step();
    end
    repeat (4) begin tx_start = 1; step(); end
    status_rd = 1; step();
    // R11: push and start together
    tx_push_valid = 1; tx_push_data = 8'h01; step();
    tx_push_valid = 1; tx_push_data = 8'h02; tx_start = 1; step();
    tx_start = 1; step();
    status_rd = 1; step();

    // R5: thresholds at both ends
    irq_dir_tx = 0; mask_rx_ovf = 1;
    rx_threshold = 3'd0;
    rx_push_valid = 1; rx_push_data = 8'h77; step();
    rx_threshold = 3'd4; step();
    rx_threshold = 3'd7;
    repeat (5) begin rx_push_valid = 1; rx_push_data = 8'h33; step(); end
    status_rd = 1; step();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      rx_push_valid = ($urandom % 3) == 0;
      rx_push_data  = 8'($urandom);
      rx_pop_ready  = ($urandom % 3) == 0;
      tx_push_valid = ($urandom % 3) == 0;
      tx_push_data  = 8'($urandom);
      tx_start      = ($urandom % 4) == 0;
      status_rd     = ($urandom % 5) == 0;
      if (($urandom % 50) == 0) begin
        rx_threshold = 3'($urandom % 6);
        irq_dir_tx   = 1'($urandom);
        mask_rx_ovf  = 1'($urandom);
        mask_tx_udf  = 1'($urandom);
      end
      step();
    end
    finish_run();
  end
endmodule